// File: doc/BRIEF.md
# Floppy DMA Register Window Multiplexer

This block sits on a simple synchronous CPU bus. It presents one 16-bit data window, a mode latch, a DMA status register and three DMA address byte registers. Bits of the mode latch steer every window access to one of six places. Two of them are DMA registers: the sector count and the DMA control word. The other four are registers of a floppy-controller core: command on write, status on read, track, sector and data. The core has its own command engine and is attached through a write side and a read side. A write that lands in the command register gives the core a one-cycle start strobe.

Window accesses are slow and hold a wait request for four cycles before they complete. All other addresses complete on the next clock. The block also owns the active-low controller interrupt bit that goes to a GPIO input port. A rising controller interrupt pulls that bit low. A status read made while no interrupt is pending releases it.

Top module: `fdma_regwin`

## Requirements
- R1: After reset the mode latch, sector count, DMA control, address bytes, command and the track, sector and data shadows are all zero. The DMA status register reads 1 (ready). `gpio_fdc_n` is 1, and `bus_wait`, `bus_ack` and `fdc_cmd_start` are 0.
- R2: A request to address 0 (the window) holds `bus_wait` high for exactly 4 cycles, then pulses `bus_ack` for one cycle with `bus_wait` low. A request to any other address pulses `bus_ack` on the cycle after the request, with no wait. Read data is valid on `bus_rdata` while `bus_ack` is high.
- R3: When mode bit 4 is 1, window reads and writes reach the 16-bit sector count (`dma_secnt`), whatever the other mode bits are.
- R4: When mode bit 4 is 0 and mode bit 3 is 1, window accesses reach the 16-bit DMA control word (`dma_ctrl`).
- R5: When mode bits 4 and 3 are both 0, mode bits 2:1 pick a controller register. 00 is command on write and status (`fdc_status`, zero-extended) on read. 01 is track, 10 is sector and 11 is data. Writes take the low 8 bits, and reads of track, sector and data return the shadow zero-extended.
- R6: A window write that lands in the command register updates `fdc_cmd` and drives `fdc_cmd_start` high for exactly the cycle in which `bus_ack` is high.
- R7: A rising edge on `fdc_irq` drives `gpio_fdc_n` to 0 on the next cycle. A window status read completed while `fdc_irq` is 0 sets it to 1. No other access changes it.
- R8: Address 1 is the write-only mode latch, which stores write-data bits 4:1 and reads as 16'hFFFF. Address 2 is the read-only DMA status register, which bus writes leave unchanged. It loads `dma_stat_d` when `dma_stat_we` is high.
- R9: Addresses 3, 4 and 5 hold the high, middle and low DMA address bytes, shown on `dma_addr[23:16]`, `[15:8]` and `[7:0]`. A write stores data bits 7:0, and a read returns the byte zero-extended.
- R10: The core updates a shadow with `fdc_upd_en`, with `fdc_upd_sel` set to 01 for track, 10 for sector or 11 for data. Selector 00 has no effect. If a CPU window write to the same shadow completes in the same cycle, the CPU value is kept.
- R11: Addresses 6 and 7 read as 16'hFFFF, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with `bus_ack` |
| bus_wait | output | 1 | Window access in progress |
| bus_ack | output | 1 | Access complete |
| fdc_cmd | output | 8 | Command register to core |
| fdc_track | output | 8 | Track shadow |
| fdc_sector | output | 8 | Sector shadow |
| fdc_data | output | 8 | Data shadow |
| fdc_cmd_start | output | 1 | One-cycle command start strobe |
| fdc_status | input | 8 | Controller status from core |
| fdc_irq | input | 1 | Controller interrupt pending, active high |
| fdc_upd_en | input | 1 | Core shadow update enable |
| fdc_upd_sel | input | 2 | Core shadow select |
| fdc_upd_data | input | 8 | Core shadow update value |
| gpio_fdc_n | output | 1 | Active-low interrupt bit for the GPIO port |
| dma_stat_we | input | 1 | DMA status load |
| dma_stat_d | input | 16 | DMA status value |
| dma_secnt | output | 16 | Sector count |
| dma_ctrl | output | 16 | DMA control word |
| dma_addr | output | 24 | DMA address bytes |

## Verification
The assertions assume a bus master that never raises `bus_req` while a window access is still waiting or in the cycle its `bus_ack` appears. Under that assumption two command strobes can never fall on adjacent cycles, and acknowledge never overlaps wait. The stimulus keeps to this rule: each request is a single-cycle pulse, and the next one is issued only after the acknowledge has been seen plus one idle cycle. `fdc_irq`, the core update port and the status load are driven freely between clock edges, including during the wait cycles of a window access.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

  typedef enum logic [2:0] {
    TGT_SECNT,
    TGT_CTRL,
    TGT_CMDST,
    TGT_TRACK,
    TGT_SECTOR,
    TGT_DATA
  } win_tgt_e;

  localparam int A_WIN  = 0;
  localparam int A_MODE = 1;
  localparam int A_STAT = 2;
  localparam int A_ADRH = 3;

  // m holds mode bits 4:1 as m[3:0]
  function automatic win_tgt_e pick_target(input logic [3:0] m);
    if (m[3]) return TGT_SECNT;
    if (m[2]) return TGT_CTRL;
    case (m[1:0])
      2'b00:   return TGT_CMDST;
      2'b01:   return TGT_TRACK;
      2'b10:   return TGT_SECTOR;
      default: return TGT_DATA;
    endcase
  endfunction

endpackage

// File: rtl/fdma_wait_seq.sv
module fdma_wait_seq #(
  parameter int WAIT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic is_win,
  output logic win_fire,
  output logic dir_fire,
  output logic bus_wait,
  output logic bus_ack
);
  localparam int CW = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;

  logic [CW-1:0] cnt;

  assign dir_fire = req && !bus_wait && !is_win;
  assign win_fire = bus_wait && (cnt == CW'(WAIT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_wait <= 1'b0;
      bus_ack  <= 1'b0;
      cnt      <= '0;
    end else begin
      bus_ack <= dir_fire || win_fire;
      if (win_fire) begin
        bus_wait <= 1'b0;
      end else if (bus_wait) begin
        cnt <= cnt + 1'b1;
      end else if (req && is_win) begin
        bus_wait <= 1'b1;
        cnt      <= '0;
      end
    end
  end

  // R2: wait does not drop before the count is reached
  a_r2_wait_stretch: assert property (@(posedge clk) disable iff (rst)
    (bus_wait && cnt != CW'(WAIT_CYC - 1)) |=> bus_wait);
  // R2: the end of a wait is an acknowledge
  a_r2_fall_acks: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_wait) |-> bus_ack);
  // R2: acknowledge never overlaps wait
  a_r2_ack_no_wait: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> !bus_wait);

endmodule

// File: rtl/fdma_fdc_regs.sv
module fdma_fdc_regs #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_sel,
  input  logic [FW-1:0] cpu_d,
  input  logic          stat_rd,
  input  logic          upd_en,
  input  logic [1:0]    upd_sel,
  input  logic [FW-1:0] upd_d,
  input  logic          irq,
  output logic [FW-1:0] cmd,
  output logic [FW-1:0] track,
  output logic [FW-1:0] sector,
  output logic [FW-1:0] data,
  output logic          start,
  output logic          gpio_n
);
  logic irq_q;

  for (genvar g = 1; g <= 3; g++) begin : g_shd
    logic [FW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                q <= '0;
      else if (cpu_we && cpu_sel == 2'(g))    q <= cpu_d;
      else if (upd_en && upd_sel == 2'(g))    q <= upd_d;
    end
  end

  assign track  = g_shd[1].q;
  assign sector = g_shd[2].q;
  assign data   = g_shd[3].q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd    <= '0;
      start  <= 1'b0;
      irq_q  <= 1'b0;
      gpio_n <= 1'b1;
    end else begin
      start <= cpu_we && cpu_sel == 2'b00;
      if (cpu_we && cpu_sel == 2'b00) cmd <= cpu_d;
      irq_q <= irq;
      if (irq && !irq_q)        gpio_n <= 1'b0;
      else if (stat_rd && !irq) gpio_n <= 1'b1;
    end
  end

  // R6: start strobe lasts one cycle
  a_r6_start_single: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
  // R7: new interrupt pulls the GPIO bit low
  a_r7_irq_low: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |=> !gpio_n);
  // R7: no release while interrupt pending
  a_r7_no_release: assert property (@(posedge clk) disable iff (rst)
    irq |=> !$rose(gpio_n));
  // R10: CPU write to track wins over core
  a_r10_cpu_wins: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_sel == 2'b01) |=> track == $past(cpu_d));

endmodule

// File: rtl/fdma_dma_regs.sv
module fdma_dma_regs #(
  parameter int DW   = 16,
  parameter int AB_N = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              secnt_we,
  input  logic              ctrl_we,
  input  logic [AB_N-1:0]   ab_we,
  input  logic [DW-1:0]     wdata,
  input  logic              stat_we,
  input  logic [DW-1:0]     stat_d,
  output logic [DW-1:0]     secnt,
  output logic [DW-1:0]     ctrl,
  output logic [DW-1:0]     stat,
  output logic [AB_N*8-1:0] addr_flat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      secnt <= '0;
      ctrl  <= '0;
      stat  <= DW'(1);
    end else begin
      if (secnt_we) secnt <= wdata;
      if (ctrl_we)  ctrl  <= wdata;
      if (stat_we)  stat  <= stat_d;
    end
  end

  for (genvar i = 0; i < AB_N; i++) begin : g_ab
    localparam int LSB = (AB_N - 1 - i) * 8;
    always_ff @(posedge clk) begin
      if (rst)           addr_flat[LSB +: 8] <= '0;
      else if (ab_we[i]) addr_flat[LSB +: 8] <= wdata[7:0];
    end
  end

  // R1: status leaves reset as ready
  a_r1_stat_ready: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> stat == DW'(1));

endmodule

// File: rtl/fdma_regwin.sv
module fdma_regwin
  import fdma_pkg::*;
#(
  parameter int DW       = 16,
  parameter int FW       = 8,
  parameter int ADDR_W   = 3,
  parameter int WAIT_CYC = 4,
  parameter int AB_N     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_wait,
  output logic              bus_ack,
  output logic [FW-1:0]     fdc_cmd,
  output logic [FW-1:0]     fdc_track,
  output logic [FW-1:0]     fdc_sector,
  output logic [FW-1:0]     fdc_data,
  output logic              fdc_cmd_start,
  input  logic [FW-1:0]     fdc_status,
  input  logic              fdc_irq,
  input  logic              fdc_upd_en,
  input  logic [1:0]        fdc_upd_sel,
  input  logic [FW-1:0]     fdc_upd_data,
  output logic              gpio_fdc_n,
  input  logic              dma_stat_we,
  input  logic [DW-1:0]     dma_stat_d,
  output logic [DW-1:0]     dma_secnt,
  output logic [DW-1:0]     dma_ctrl,
  output logic [AB_N*8-1:0] dma_addr
);
  localparam logic [DW-1:0] OPEN = '1;

  logic          win_fire, dir_fire, is_win;
  logic          op_we;
  logic [DW-1:0] op_wdata;
  logic [3:0]    mode_q;
  win_tgt_e      tgt;
  logic [DW-1:0] dma_stat;
  logic [AB_N-1:0] ab_we;
  logic [DW-1:0] rd_val;
  logic          fdc_wr, stat_rd, acc_rd;

  assign is_win = bus_addr == ADDR_W'(A_WIN);
  assign tgt    = pick_target(mode_q);

  fdma_wait_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk(clk), .rst(rst), .req(bus_req), .is_win(is_win),
    .win_fire(win_fire), .dir_fire(dir_fire),
    .bus_wait(bus_wait), .bus_ack(bus_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_we    <= 1'b0;
      op_wdata <= '0;
      mode_q   <= '0;
    end else begin
      if (bus_req && !bus_wait && is_win) begin
        op_we    <= bus_we;
        op_wdata <= bus_wdata;
      end
      if (dir_fire && bus_we && bus_addr == ADDR_W'(A_MODE))
        mode_q <= bus_wdata[4:1];
    end
  end

  for (genvar i = 0; i < AB_N; i++) begin : g_abwe
    assign ab_we[i] = dir_fire && bus_we && bus_addr == ADDR_W'(A_ADRH + i);
  end

  assign fdc_wr  = win_fire && op_we && tgt != TGT_SECNT && tgt != TGT_CTRL;
  assign stat_rd = win_fire && !op_we && tgt == TGT_CMDST;

  fdma_dma_regs #(.DW(DW), .AB_N(AB_N)) u_dma (
    .clk(clk), .rst(rst),
    .secnt_we(win_fire && op_we && tgt == TGT_SECNT),
    .ctrl_we(win_fire && op_we && tgt == TGT_CTRL),
    .ab_we(ab_we), .wdata(win_fire ? op_wdata : bus_wdata),
    .stat_we(dma_stat_we), .stat_d(dma_stat_d),
    .secnt(dma_secnt), .ctrl(dma_ctrl), .stat(dma_stat),
    .addr_flat(dma_addr)
  );

  fdma_fdc_regs #(.FW(FW)) u_fdc (
    .clk(clk), .rst(rst),
    .cpu_we(fdc_wr), .cpu_sel(mode_q[1:0]), .cpu_d(op_wdata[FW-1:0]),
    .stat_rd(stat_rd),
    .upd_en(fdc_upd_en), .upd_sel(fdc_upd_sel), .upd_d(fdc_upd_data),
    .irq(fdc_irq),
    .cmd(fdc_cmd), .track(fdc_track), .sector(fdc_sector), .data(fdc_data),
    .start(fdc_cmd_start), .gpio_n(gpio_fdc_n)
  );

  always_comb begin
    rd_val = OPEN;
    if (win_fire) begin
      case (tgt)
        TGT_SECNT:  rd_val = dma_secnt;
        TGT_CTRL:   rd_val = dma_ctrl;
        TGT_CMDST:  rd_val = {{(DW-FW){1'b0}}, fdc_status};
        TGT_TRACK:  rd_val = {{(DW-FW){1'b0}}, fdc_track};
        TGT_SECTOR: rd_val = {{(DW-FW){1'b0}}, fdc_sector};
        default:    rd_val = {{(DW-FW){1'b0}}, fdc_data};
      endcase
    end else begin
      if (bus_addr == ADDR_W'(A_STAT)) rd_val = dma_stat;
      for (int i = 0; i < AB_N; i++)
        if (bus_addr == ADDR_W'(A_ADRH + i))
          rd_val = {{(DW-8){1'b0}}, dma_addr[(AB_N-1-i)*8 +: 8]};
    end
  end

  assign acc_rd = (win_fire && !op_we) || (dir_fire && !bus_we);

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (acc_rd) bus_rdata <= rd_val;
  end

  // R3: window write with mode bit 4 reaches sector count
  a_r3_secnt: assert property (@(posedge clk) disable iff (rst)
    (win_fire && op_we && mode_q[3]) |=> dma_secnt == $past(op_wdata));
  // R8: mode address reads as all ones
  a_r8_mode_open: assert property (@(posedge clk) disable iff (rst)
    (dir_fire && !bus_we && bus_addr == ADDR_W'(A_MODE)) |=> bus_rdata == OPEN);
  // R6: start strobe coincides with acknowledge
  a_r6_start_ack: assert property (@(posedge clk) disable iff (rst)
    fdc_cmd_start |-> bus_ack);

endmodule

// File: tb/fdma_regwin_bench.sv
module fdma_regwin_bench;
  localparam int WAITC = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 0, bus_we = 0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic bus_wait, bus_ack;
  logic [7:0] fdc_cmd, fdc_track, fdc_sector, fdc_data;
  logic fdc_cmd_start;
  logic [7:0] fdc_status = 8'h00;
  logic fdc_irq = 0, fdc_upd_en = 0;
  logic [1:0] fdc_upd_sel = 0;
  logic [7:0] fdc_upd_data = 0;
  logic gpio_fdc_n;
  logic dma_stat_we = 0;
  logic [15:0] dma_stat_d = 0, dma_secnt, dma_ctrl;
  logic [23:0] dma_addr;

  int n_chk = 0, n_bad = 0;
  string cur_tag = "R5";
  bit done = 0;

  always #5 clk = ~clk;

  fdma_regwin u_fdma_regwin (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait), .bus_ack(bus_ack),
    .fdc_cmd(fdc_cmd), .fdc_track(fdc_track), .fdc_sector(fdc_sector), .fdc_data(fdc_data),
    .fdc_cmd_start(fdc_cmd_start), .fdc_status(fdc_status), .fdc_irq(fdc_irq),
    .fdc_upd_en(fdc_upd_en), .fdc_upd_sel(fdc_upd_sel), .fdc_upd_data(fdc_upd_data),
    .gpio_fdc_n(gpio_fdc_n), .dma_stat_we(dma_stat_we), .dma_stat_d(dma_stat_d),
    .dma_secnt(dma_secnt), .dma_ctrl(dma_ctrl), .dma_addr(dma_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit m_ack, m_wait, m_start, m_gpio, m_busy, m_owe, m_rd, m_pirq;
  int m_cnt;
  logic [15:0] m_rdata, m_owd, m_secnt, m_ctrl, m_stat;
  logic [3:0] m_mode;
  logic [7:0] m_ab [3];
  logic [7:0] m_reg [4];

  function automatic void m_access(input bit win, input logic [2:0] a,
                                   input bit we, input logic [15:0] d);
    if (!we) m_rd = 1;
    if (win) begin
      if (m_mode[3]) begin
        if (we) m_secnt = d; else m_rdata = m_secnt;
      end else if (m_mode[2]) begin
        if (we) m_ctrl = d; else m_rdata = m_ctrl;
      end else if (we) begin
        m_reg[m_mode[1:0]] = d[7:0];
        if (m_mode[1:0] == 2'b00) m_start = 1;
      end else if (m_mode[1:0] == 2'b00) begin
        m_rdata = {8'h00, fdc_status};
        if (!fdc_irq) m_gpio = 1;
      end else begin
        m_rdata = {8'h00, m_reg[m_mode[1:0]]};
      end
    end else begin
      case (a)
        3'd1: if (we) m_mode = d[4:1]; else m_rdata = 16'hFFFF;
        3'd2: if (!we) m_rdata = m_stat;
        3'd3, 3'd4, 3'd5: if (we) m_ab[a-3] = d[7:0]; else m_rdata = {8'h00, m_ab[a-3]};
        default: if (!we) m_rdata = 16'hFFFF;
      endcase
    end
  endfunction

  always @(posedge clk) begin
    bit rose;
    if (rst) begin
      m_ack = 0; m_wait = 0; m_start = 0; m_gpio = 1; m_busy = 0; m_cnt = 0;
      m_rd = 0; m_pirq = 0; m_rdata = 0; m_owe = 0; m_owd = 0;
      m_secnt = 0; m_ctrl = 0; m_stat = 16'd1; m_mode = 0;
      foreach (m_ab[i]) m_ab[i] = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
    end else begin
      m_ack = 0; m_start = 0; m_rd = 0;
      rose = fdc_irq && !m_pirq;
      m_pirq = fdc_irq;
      if (dma_stat_we) m_stat = dma_stat_d;
      if (fdc_upd_en && fdc_upd_sel != 0) m_reg[fdc_upd_sel] = fdc_upd_data;
      if (m_busy) begin
        if (m_cnt == WAITC - 1) begin
          m_access(1, 3'd0, m_owe, m_owd);
          m_busy = 0; m_ack = 1;
        end else m_cnt++;
      end else if (bus_req) begin
        if (bus_addr == 3'd0) begin
          m_busy = 1; m_cnt = 0; m_owe = bus_we; m_owd = bus_wdata;
        end else begin
          m_access(0, bus_addr, bus_we, bus_wdata);
          m_ack = 1;
        end
      end
      if (rose) m_gpio = 0;
    end
    m_wait = m_busy;
    #2;
    if (!done) begin
      chk("R2 ack", bus_ack, m_ack);
      chk("R2 wait", bus_wait, m_wait);
      if (m_ack && m_rd) chk({cur_tag, " rdata"}, bus_rdata, m_rdata);
      chk("R6 start", fdc_cmd_start, m_start);
      chk("R7 gpio", gpio_fdc_n, m_gpio);
      chk("R6 cmd", fdc_cmd, m_reg[0]);
      chk("R10 track", fdc_track, m_reg[1]);
      chk("R10 sector", fdc_sector, m_reg[2]);
      chk("R10 data", fdc_data, m_reg[3]);
      chk("R3 secnt", dma_secnt, m_secnt);
      chk("R4 ctrl", dma_ctrl, m_ctrl);
      chk("R9 addr", dma_addr, {m_ab[0], m_ab[1], m_ab[2]});
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(input bit we, input logic [2:0] a, input logic [15:0] d,
                    output logic [15:0] rd);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0;
    while (!bus_ack) @(negedge clk);
    rd = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    logic [15:0] x;
    op(1, a, d, x);
  endtask

  task automatic rdc(input string tag, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] x;
    op(0, a, 16'h0, x);
    chk(tag, x, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int wcnt;
    logic [15:0] x;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 gpio", gpio_fdc_n, 1);
    chk("R1 secnt", dma_secnt, 0);
    chk("R1 addr", dma_addr, 0);
    chk("R1 wait", bus_wait, 0);
    cur_tag = "R1";
    rdc("R1 stat", 3'd2, 16'h0001);
    fdc_status = 8'hC3;
    cur_tag = "R5";
    rdc("R5 status mode0", 3'd0, 16'h00C3);

    // R2 wait length
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = 0;
    @(negedge clk); bus_req = 0;
    wcnt = 0;
    while (!bus_ack) begin wcnt++; @(negedge clk); end
    chk("R2 wait cycles", wcnt, WAITC);
    chk("R2 ack no wait", bus_wait, 0);

    // R3 sector count
    cur_tag = "R3";
    wr(3'd1, 16'h0010);
    wr(3'd0, 16'h1234);
    chk("R3 secnt", dma_secnt, 16'h1234);
    wr(3'd1, 16'h001E);
    rdc("R3 secnt other bits", 3'd0, 16'h1234);
    // R4 control
    cur_tag = "R4";
    wr(3'd1, 16'h0008);
    wr(3'd0, 16'hBEEF);
    chk("R4 ctrl", dma_ctrl, 16'hBEEF);
    wr(3'd1, 16'h000E);
    rdc("R4 ctrl read", 3'd0, 16'hBEEF);
    // R5 / R6 controller registers
    cur_tag = "R5";
    wr(3'd1, 16'h0000);
    op(1, 3'd0, 16'hAA5A, x);
    chk("R6 start with ack", fdc_cmd_start, 1);
    chk("R6 cmd", fdc_cmd, 8'h5A);
    @(negedge clk);
    chk("R6 start one cycle", fdc_cmd_start, 0);
    wr(3'd1, 16'h0002); wr(3'd0, 16'h0011);
    rdc("R5 track", 3'd0, 16'h0011);
    wr(3'd1, 16'h0004); wr(3'd0, 16'h0022);
    rdc("R5 sector", 3'd0, 16'h0022);
    wr(3'd1, 16'h0006); wr(3'd0, 16'h0033);
    rdc("R5 data", 3'd0, 16'h0033);
    chk("R5 no start on data", fdc_cmd, 8'h5A);

    // R7 interrupt line
    wr(3'd1, 16'h0000);
    @(negedge clk); fdc_irq = 1;
    repeat (2) @(negedge clk);
    chk("R7 irq low", gpio_fdc_n, 0);
    rdc("R7 status read irq high", 3'd0, 16'h00C3);
    chk("R7 held while irq", gpio_fdc_n, 0);
    fdc_irq = 0;
    wr(3'd1, 16'h0002);
    rdc("R7 track read", 3'd0, 16'h0011);
    chk("R7 track read no release", gpio_fdc_n, 0);
    wr(3'd1, 16'h0000);
    rdc("R7 status read", 3'd0, 16'h00C3);
    @(negedge clk);
    chk("R7 released", gpio_fdc_n, 1);

    // R8 mode and status
    cur_tag = "R8";
    rdc("R8 mode reads ones", 3'd1, 16'hFFFF);
    wr(3'd2, 16'h0055);
    rdc("R8 stat read only", 3'd2, 16'h0001);
    @(negedge clk); dma_stat_we = 1; dma_stat_d = 16'h00A4;
    @(negedge clk); dma_stat_we = 0;
    rdc("R8 stat load", 3'd2, 16'h00A4);

    // R9 address bytes
    cur_tag = "R9";
    wr(3'd3, 16'hFF12); wr(3'd4, 16'h0034); wr(3'd5, 16'h7756);
    chk("R9 dma_addr", dma_addr, 24'h123456);
    rdc("R9 high", 3'd3, 16'h0012);
    rdc("R9 low", 3'd5, 16'h0056);

    // R10 core updates
    cur_tag = "R10";
    @(negedge clk); fdc_upd_en = 1; fdc_upd_sel = 2'b10; fdc_upd_data = 8'h99;
    @(negedge clk); fdc_upd_sel = 2'b00; fdc_upd_data = 8'hEE;
    @(negedge clk); fdc_upd_en = 0;
    chk("R10 sector update", fdc_sector, 8'h99);
    chk("R10 sel 00 no effect", fdc_cmd, 8'h5A);
    wr(3'd1, 16'h0004);
    rdc("R10 sector read", 3'd0, 16'h0099);
    wr(3'd1, 16'h0002);
    @(negedge clk); fdc_upd_en = 1; fdc_upd_sel = 2'b01; fdc_upd_data = 8'h77;
    op(1, 3'd0, 16'h0044, x);
    chk("R10 cpu wins", fdc_track, 8'h44);
    fdc_upd_en = 0;

    // R11 unmapped
    cur_tag = "R11";
    rdc("R11 read 6", 3'd6, 16'hFFFF);
    wr(3'd7, 16'h0000);
    chk("R11 write no effect", dma_addr, 24'h123456);
    rdc("R11 read 7", 3'd7, 16'hFFFF);

    // mixed traffic, checked by the model
    cur_tag = "R5";
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      fdc_irq = ($urandom_range(0, 5) == 0) ? ~fdc_irq : fdc_irq;
      fdc_status = 8'($urandom);
      fdc_upd_en = ($urandom_range(0, 3) == 0);
      fdc_upd_sel = 2'($urandom);
      fdc_upd_data = 8'($urandom);
      dma_stat_we = ($urandom_range(0, 7) == 0);
      dma_stat_d = 16'($urandom);
      op($urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)), 16'($urandom), x);
      fdc_upd_en = 0; dma_stat_we = 0;
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule